// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block owns the fetch address of a simple in-order processor whose instructions are 16 bits wide. Each cycle it either steps the fetch address forward by one instruction or redirects it to a branch target. Branch requests come from the execute stage. Each request carries a branch kind, a target source (a PC-relative immediate or a register value), the address of the branch instruction and the current true/false status flag.

Two redirect styles are supported. A delayed branch lets exactly one following instruction, the slot instruction, run before the fetch address moves to the target. The target is captured when the branch is accepted, so a slot instruction that overwrites the source register cannot move the branch. An immediate branch redirects at once and raises a one-cycle flush so that the pipeline discards the instruction it has already fetched.

Conditional kinds of both styles test the status flag. A branch request that arrives while a slot is pending is refused and reported on an error output. A stall input freezes all sequencing state.

Top module: `dbr_pc_seq`

## Requirements
- R1: On a clock edge with `rst_n` low, `fetch_pc` becomes `RESET_PC` (default 0x0000_1000), and `flush`, `slot_active` and `slot_err` become 0.
- R2: On a non-stalled edge with no pending slot and no accepted redirect, `fetch_pc` advances by 2.
- R3: A PC-relative target (`br_use_reg`=0) equals `br_pc` + 4 + (sign-extended `br_offset` shifted left by one). A register target (`br_use_reg`=1) equals `br_reg_val` with bit 0 forced to 0.
- R4: For a taken delayed kind, the edge that accepts it advances `fetch_pc` by 2 and sets `slot_active`. On the next non-stalled edge, `fetch_pc` becomes the target and `slot_active` returns to 0.
- R5: The target of a delayed branch is the one computed on its accepting edge. Later changes of `br_reg_val`, `br_pc` or `br_offset` do not change where `fetch_pc` goes.
- R6: A taken immediate kind loads the target into `fetch_pc` on its accepting edge and sets `flush` high for exactly the following cycle.
- R7: The `br_kind` encodings are: 0 delayed always, 1 immediate always, 2 immediate if flag=1, 3 immediate if flag=0, 4 delayed if flag=1, 5 delayed if flag=0. A conditional kind whose test fails behaves as R2, with no flush and no slot.
- R8: A request with `br_valid`=1 on a non-stalled edge while `slot_active`=1 is not taken. `slot_err` is high for the following cycle, and the pending redirect still goes to the latched target.
- R9: On an edge with `stall`=1, `fetch_pc`, `slot_active` and the latched target keep their values, any request is ignored, and `flush` and `slot_err` become 0.
- R10: `br_kind` codes 6 and 7 are not branches. They behave as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Freeze all sequencing state this cycle |
| br_valid | input | 1 | A branch request is present |
| br_kind | input | 3 | Branch kind code (see R7, R10) |
| br_use_reg | input | 1 | 1: target from register, 0: PC-relative |
| br_pc | input | AW | Address of the branch instruction |
| br_offset | input | OW | Signed PC-relative offset in instruction units |
| br_reg_val | input | AW | Register value used as the target |
| t_flag | input | 1 | Status flag tested by conditional kinds |
| fetch_pc | output | AW | Current fetch address |
| flush | output | 1 | Discard the already-fetched instruction |
| slot_active | output | 1 | The current instruction is a delay slot |
| slot_err | output | 1 | A branch request was refused in a delay slot |

## Verification
The assertions check on every cycle the local invariants. These are the plain two-byte step, the stall freeze, the one-cycle life of a slot, and the rule that `flush` and `slot_err` each appear only after a request of the right kind and never together with a pending slot. Only the bench scenarios can show that targets are right. This covers PC-relative arithmetic with negative offsets, register targets with the low bit cleared, a target that holds while the source register changes in the slot or during a stall, and the correct taken or not-taken outcome for each flag-testing kind. The bench compares all four outputs against a behavioural model after every edge.

// File: rtl/dbr_pkg.sv
`timescale 1ns/1ps
// Package: shared branch-kind encoding and decode result for the
// delayed-branch PC sequencer. Assumes a 3-bit kind field from execute.
package dbr_pkg;

    typedef enum logic [2:0] {
        BK_DLY_ALWAYS = 3'd0,
        BK_NOW_ALWAYS = 3'd1,
        BK_NOW_IF_T   = 3'd2,
        BK_NOW_IF_F   = 3'd3,
        BK_DLY_IF_T   = 3'd4,
        BK_DLY_IF_F   = 3'd5,
        BK_RSV_6      = 3'd6,
        BK_RSV_7      = 3'd7
    } br_kind_e;

    typedef struct packed {
        logic is_branch;   // kind is a defined branch
        logic delayed;     // kind has a delay slot
        logic taken;       // condition satisfied
    } br_dec_t;

    // Decode a kind code against the status flag.
    function automatic br_dec_t decode_kind(input logic [2:0] code, input logic t);
        br_dec_t d;
        d = '0;
        case (br_kind_e'(code))
            BK_DLY_ALWAYS: begin d.is_branch = 1'b1; d.delayed = 1'b1; d.taken = 1'b1; end
            BK_NOW_ALWAYS: begin d.is_branch = 1'b1; d.delayed = 1'b0; d.taken = 1'b1; end
            BK_NOW_IF_T:   begin d.is_branch = 1'b1; d.delayed = 1'b0; d.taken = t;    end
            BK_NOW_IF_F:   begin d.is_branch = 1'b1; d.delayed = 1'b0; d.taken = ~t;   end
            BK_DLY_IF_T:   begin d.is_branch = 1'b1; d.delayed = 1'b1; d.taken = t;    end
            BK_DLY_IF_F:   begin d.is_branch = 1'b1; d.delayed = 1'b1; d.taken = ~t;   end
            default:       d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dbr_target_calc.sv
`timescale 1ns/1ps
// Module: dbr_target_calc
// Forms the branch target from either a PC-relative offset or a register
// value. Assumes the branch address is halfword aligned. A parameter
// selects whether register targets have bit 0 cleared.
module dbr_target_calc #(
    parameter int AW            = 32,
    parameter int OW            = 8,
    parameter bit CLEAR_REG_LSB = 1'b1
) (
    input  logic          use_reg,
    input  logic [AW-1:0] branch_pc,
    input  logic [OW-1:0] offset,
    input  logic [AW-1:0] reg_val,
    output logic [AW-1:0] target
);
    localparam int EXT = AW - OW - 1;
    localparam logic [AW-1:0] PIPE_AHEAD = AW'(4);

    logic [AW-1:0] rel_disp;
    logic [AW-1:0] rel_tgt;
    logic [AW-1:0] reg_tgt;

    // Sign-extend the offset and scale it to bytes.
    always_comb begin
        rel_disp = {{EXT{offset[OW-1]}}, offset, 1'b0};
    end

    // PC-relative target: branch address plus pipeline distance plus displacement.
    always_comb begin
        rel_tgt = branch_pc + PIPE_AHEAD + rel_disp;
    end

    generate
        if (CLEAR_REG_LSB) begin : g_reg_align
            // Force register targets onto an instruction boundary.
            always_comb reg_tgt = {reg_val[AW-1:1], 1'b0};
        end else begin : g_reg_raw
            // Pass register targets through untouched.
            always_comb reg_tgt = reg_val;
        end
    endgenerate

    // Pick the target source.
    always_comb begin
        target = use_reg ? reg_tgt : rel_tgt;
    end
endmodule

// File: rtl/dbr_branch_resolve.sv
`timescale 1ns/1ps
// Module: dbr_branch_resolve
// Decides what an incoming request does this cycle: start a delayed
// redirect, redirect at once, or be refused because a slot is pending.
// Stall is applied by the state module. This module only classifies.
module dbr_branch_resolve
    import dbr_pkg::*;
(
    input  logic       req_valid,
    input  logic [2:0] req_kind,
    input  logic       flag_t,
    input  logic       slot_pending,
    output logic       take_delayed,
    output logic       take_now,
    output logic       slot_violation
);
    br_dec_t dec;

    // Decode the kind against the flag.
    always_comb begin
        dec = decode_kind(req_kind, flag_t);
    end

    // Classify the request. Any request in a slot is a violation.
    always_comb begin
        slot_violation = req_valid & slot_pending;
        take_delayed   = req_valid & ~slot_pending & dec.is_branch & dec.taken &  dec.delayed;
        take_now       = req_valid & ~slot_pending & dec.is_branch & dec.taken & ~dec.delayed;
    end
endmodule

// File: rtl/dbr_pc_state.sv
`timescale 1ns/1ps
// Module: dbr_pc_state
// Holds the fetch address, the latched delayed target, the slot-pending
// flag and the one-cycle flush / error pulses. Assumes the classification
// inputs are already qualified against the pending slot.
module dbr_pc_state #(
    parameter int              AW       = 32,
    parameter logic [AW-1:0]   RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          take_delayed,
    input  logic          take_now,
    input  logic          slot_violation,
    input  logic [AW-1:0] new_target,
    output logic [AW-1:0] pc,
    output logic          slot_pending,
    output logic          flush_pulse,
    output logic          err_pulse
);
    localparam logic [AW-1:0] INSN_BYTES = AW'(2);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] tgt_q;
    logic          slot_q;
    logic          flush_q;
    logic          err_q;

    // Sequencing registers: reset, freeze on stall, otherwise step or redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC;
            tgt_q   <= '0;
            slot_q  <= 1'b0;
            flush_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (stall) begin
            flush_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            flush_q <= take_now;
            err_q   <= slot_violation;
            if (slot_q) begin
                pc_q   <= tgt_q;
                slot_q <= 1'b0;
            end else if (take_now) begin
                pc_q <= new_target;
            end else begin
                pc_q <= pc_q + INSN_BYTES;
                if (take_delayed) begin
                    tgt_q  <= new_target;
                    slot_q <= 1'b1;
                end
            end
        end
    end

    // Drive outputs from the registers.
    always_comb begin
        pc           = pc_q;
        slot_pending = slot_q;
        flush_pulse  = flush_q;
        err_pulse    = err_q;
    end
endmodule

// File: rtl/dbr_pc_seq.sv
`timescale 1ns/1ps
// Module: dbr_pc_seq (top)
// Program-counter sequencer with delayed, immediate and flag-conditional
// branches. Assumes one request at most per cycle from execute and
// halfword-aligned branch addresses.
module dbr_pc_seq #(
    parameter int            AW            = 32,
    parameter int            OW            = 8,
    parameter logic [AW-1:0] RESET_PC      = 32'h0000_1000,
    parameter bit            CLEAR_REG_LSB = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic          br_valid,
    input  logic [2:0]    br_kind,
    input  logic          br_use_reg,
    input  logic [AW-1:0] br_pc,
    input  logic [OW-1:0] br_offset,
    input  logic [AW-1:0] br_reg_val,
    input  logic          t_flag,
    output logic [AW-1:0] fetch_pc,
    output logic          flush,
    output logic          slot_active,
    output logic          slot_err
);
    logic [AW-1:0] tgt_w;
    logic          take_dly_w;
    logic          take_now_w;
    logic          viol_w;
    logic          slot_w;

    dbr_target_calc #(.AW(AW), .OW(OW), .CLEAR_REG_LSB(CLEAR_REG_LSB)) u_tgt (
        .use_reg   (br_use_reg),
        .branch_pc (br_pc),
        .offset    (br_offset),
        .reg_val   (br_reg_val),
        .target    (tgt_w)
    );

    dbr_branch_resolve u_res (
        .req_valid      (br_valid),
        .req_kind       (br_kind),
        .flag_t         (t_flag),
        .slot_pending   (slot_w),
        .take_delayed   (take_dly_w),
        .take_now       (take_now_w),
        .slot_violation (viol_w)
    );

    dbr_pc_state #(.AW(AW), .RESET_PC(RESET_PC)) u_st (
        .clk            (clk),
        .rst_n          (rst_n),
        .stall          (stall),
        .take_delayed   (take_dly_w),
        .take_now       (take_now_w),
        .slot_violation (viol_w),
        .new_target     (tgt_w),
        .pc             (fetch_pc),
        .slot_pending   (slot_w),
        .flush_pulse    (flush),
        .err_pulse      (slot_err)
    );

    // Expose the slot state.
    always_comb slot_active = slot_w;
endmodule

// File: rtl/dbr_pc_seq_chk.sv
`timescale 1ns/1ps
// Module: dbr_pc_seq_chk
// Temporal checks on the sequencer ports, attached by bind.
module dbr_pc_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall,
    input logic          br_valid,
    input logic [AW-1:0] fetch_pc,
    input logic          flush,
    input logic          slot_active,
    input logic          slot_err
);
    logic past_ok;

    // Mark when one full cycle out of reset has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (!stall && !br_valid && !slot_active) |=> fetch_pc == $past(fetch_pc) + AW'(2));

    p_slot_once_r4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (slot_active && !stall) |=> !slot_active);

    p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        flush |-> $past(br_valid && !stall && !slot_active));

    p_flush_excl_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !(flush && slot_active));

    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        slot_err |-> $past(slot_active && br_valid && !stall));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        stall |=> (fetch_pc == $past(fetch_pc)) && (slot_active == $past(slot_active))
                  && !flush && !slot_err);
endmodule

bind dbr_pc_seq dbr_pc_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall       (stall),
    .br_valid    (br_valid),
    .fetch_pc    (fetch_pc),
    .flush       (flush),
    .slot_active (slot_active),
    .slot_err    (slot_err)
);

// File: tb/dbr_pc_seq_tb_top.sv
`timescale 1ns/1ps
module dbr_pc_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic        br_valid;
    logic [2:0]  br_kind;
    logic        br_use_reg;
    logic [31:0] br_pc;
    logic [7:0]  br_offset;
    logic [31:0] br_reg_val;
    logic        t_flag;
    logic [31:0] fetch_pc;
    logic        flush;
    logic        slot_active;
    logic        slot_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    logic [31:0] m_pc;
    logic [31:0] m_tgt;
    bit          m_slot, m_flush, m_err;

    always #2.5 clk = ~clk;

    dbr_pc_seq dut_i (
        .clk(clk), .rst_n(rst_n), .stall(stall), .br_valid(br_valid),
        .br_kind(br_kind), .br_use_reg(br_use_reg), .br_pc(br_pc),
        .br_offset(br_offset), .br_reg_val(br_reg_val), .t_flag(t_flag),
        .fetch_pc(fetch_pc), .flush(flush), .slot_active(slot_active),
        .slot_err(slot_err)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Requirement-level target rule (R3).
    function automatic logic [31:0] spec_target(input bit use_reg, input logic [31:0] bpc,
                                                input logic [7:0] off, input logic [31:0] rv);
        int disp;
        disp = int'($signed(off)) * 2;
        if (use_reg) return rv & ~32'd1;
        return bpc + 32'd4 + 32'(disp);
    endfunction

    // Model one clock edge from the requirements.
    task automatic model_edge();
        bit is_br, dly, tk;
        is_br = (br_kind <= 3'd5);
        dly   = (br_kind == 3'd0) || (br_kind == 3'd4) || (br_kind == 3'd5);
        case (br_kind)
            3'd0, 3'd1: tk = 1'b1;
            3'd2, 3'd4: tk = t_flag;
            3'd3, 3'd5: tk = !t_flag;
            default:    tk = 1'b0;
        endcase
        if (!rst_n) begin
            m_pc = 32'h0000_1000; m_slot = 0; m_flush = 0; m_err = 0; m_tgt = 0;
        end else if (stall) begin
            m_flush = 0; m_err = 0;
        end else if (m_slot) begin
            m_err = br_valid; m_flush = 0; m_pc = m_tgt; m_slot = 0;
        end else begin
            m_err = 0; m_flush = 0;
            if (br_valid && is_br && tk && !dly) begin
                m_pc = spec_target(br_use_reg, br_pc, br_offset, br_reg_val);
                m_flush = 1;
            end else begin
                if (br_valid && is_br && tk) begin
                    m_tgt = spec_target(br_use_reg, br_pc, br_offset, br_reg_val);
                    m_slot = 1;
                end
                m_pc = m_pc + 32'd2;
            end
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "fetch_pc", fetch_pc, m_pc);
        check(tag, "flush", {31'd0, flush}, {31'd0, m_flush});
        check(tag, "slot_active", {31'd0, slot_active}, {31'd0, m_slot});
        check(tag, "slot_err", {31'd0, slot_err}, {31'd0, m_err});
    endtask

    // Drive at negedge, model the posedge, compare at the next negedge.
    task automatic step(input bit v, input logic [2:0] k, input bit rg, input logic [31:0] bpc,
                        input logic [7:0] off, input logic [31:0] rv, input bit t,
                        input bit st, input string tag);
        br_valid = v; br_kind = k; br_use_reg = rg; br_pc = bpc;
        br_offset = off; br_reg_val = rv; t_flag = t; stall = st;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 3'd0, 0, 32'd0, 8'd0, 32'd0, 0, 0, tag);
    endtask

    initial begin
        rst_n = 1'b0; stall = 0; br_valid = 0; br_kind = 0; br_use_reg = 0;
        br_pc = 0; br_offset = 0; br_reg_val = 0; t_flag = 0;
        @(negedge clk);
        @(posedge clk); model_edge();
        @(negedge clk);
        compare("R1");
        check("R1", "reset pc literal", fetch_pc, 32'h0000_1000);
        rst_n = 1'b1;

        // R2 plain stepping
        for (int i = 0; i < 3; i++) idle("R2");
        check("R2", "pc after 3 steps", fetch_pc, 32'h0000_1006);

        // R4/R3 delayed PC-relative with negative offset
        step(1, 3'd0, 0, 32'h0000_1004, 8'hF0, 32'd0, 0, 0, "R4");
        check("R4", "slot raised", {31'd0, slot_active}, 32'd1);
        idle("R4");
        check("R3", "rel target", fetch_pc, 32'h0000_1004 + 32'd4 - 32'd32);

        // R5 register delayed target, register rewritten during slot
        step(1, 3'd0, 1, 32'h0000_0FE8, 8'd0, 32'h0000_2001, 0, 0, "R5");
        step(0, 3'd0, 1, 32'h0000_0FEA, 8'd0, 32'h0000_3000, 0, 0, "R5");
        check("R5", "latched reg target", fetch_pc, 32'h0000_2000);

        // R6 immediate branch with flush
        step(1, 3'd1, 0, 32'h0000_2002, 8'h10, 32'd0, 0, 0, "R6");
        check("R6", "flush high", {31'd0, flush}, 32'd1);
        idle("R6");
        check("R6", "flush one cycle", {31'd0, flush}, 32'd0);

        // R7 conditional kinds
        step(1, 3'd2, 0, 32'h0000_2024, 8'h04, 32'd0, 1, 0, "R7");
        step(1, 3'd2, 0, 32'h0000_2030, 8'h04, 32'd0, 0, 0, "R7");
        step(1, 3'd3, 0, 32'h0000_2034, 8'hFE, 32'd0, 0, 0, "R7");
        step(1, 3'd3, 0, 32'h0000_2038, 8'h08, 32'd0, 1, 0, "R7");
        step(1, 3'd4, 1, 32'h0000_2040, 8'd0, 32'h0000_4000, 0, 0, "R7");
        step(1, 3'd5, 1, 32'h0000_2040, 8'd0, 32'h0000_4400, 0, 0, "R7");
        idle("R7");
        check("R7", "cond delayed target", fetch_pc, 32'h0000_4400);
        step(1, 3'd4, 0, 32'h0000_4400, 8'h02, 32'd0, 1, 0, "R7");
        idle("R7");

        // R8 branch request inside a slot
        step(1, 3'd0, 1, 32'h0000_5000, 8'd0, 32'h0000_6000, 0, 0, "R8");
        step(1, 3'd1, 1, 32'h0000_5002, 8'd0, 32'h0000_7000, 0, 0, "R8");
        check("R8", "err raised", {31'd0, slot_err}, 32'd1);
        check("R8", "latched target kept", fetch_pc, 32'h0000_6000);
        idle("R8");

        // R9 stall with slot pending and a request present
        step(1, 3'd0, 1, 32'h0000_6002, 8'd0, 32'h0000_8000, 0, 0, "R9");
        step(1, 3'd1, 1, 32'h0000_6004, 8'd0, 32'h0000_9000, 0, 1, "R9");
        step(0, 3'd0, 1, 32'h0000_6004, 8'd0, 32'h0000_9100, 0, 1, "R9");
        idle("R9");
        check("R9", "target after stall", fetch_pc, 32'h0000_8000);
        step(1, 3'd1, 0, 32'h0000_8000, 8'h20, 32'd0, 0, 1, "R9");
        idle("R9");

        // R10 reserved kinds
        step(1, 3'd6, 0, 32'h0000_8004, 8'h20, 32'd0, 1, 0, "R10");
        step(1, 3'd7, 1, 32'h0000_8006, 8'd0, 32'h0000_A000, 0, 0, "R10");
        check("R10", "no redirect", {31'd0, flush | slot_active}, 32'd0);

        // R1 again: reset mid-slot
        step(1, 3'd0, 0, 32'h0000_8008, 8'h10, 32'd0, 0, 0, "R1");
        rst_n = 1'b0;
        idle("R1");
        rst_n = 1'b1;
        idle("R2");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule